// File: doc/BRIEF.md
# Call, Return and Stack Sequencer

This block runs the multi-cycle control-transfer and stack operations of an 8-bit processor core with a 16-bit program counter and a 16-bit stack pointer. It performs three kinds of subroutine call: absolute, short call into a fixed page, and indirect through a small vector table. It also performs a software trap, three kinds of return, and push and pop of either the status byte or a 16-bit register pair. The stack pointer is held inside the block. The caller supplies the decoded operation code, an operand field and the current program counter, status byte, register pair and interrupt-enable bit. The block reaches the stack and the vector locations through a byte-wide memory port.

An operation starts with a one-cycle `start` while the block is idle. The block then makes at most one memory access per cycle and pads the rest with idle cycles. As a result, `done` always appears after the fixed cycle count of that operation. The updated program counter, stack pointer, status byte, register pair and interrupt-enable bit appear on the outputs from the cycle after `done`. They hold until the next operation is accepted.

Top module: `crs_sequencer`

## Requirements
- R1: `start` is accepted only while `busy` is low; a `start` raised in any busy cycle, the `done` cycle included, has no effect on the running operation and starts nothing.
- R2: With acceptance at clock edge 0, `done` is high for exactly one cycle, the N-th cycle after that edge. N is 7 for op 0, 5 for op 1, 6 for ops 2 to 6, 2 for ops 7 and 8, 4 for ops 9 and 10, and 1 for ops 11 to 15. The results are visible from the next cycle.
- R3: Op 0 (absolute call): the byte (pc+3)[15:8] is written to SP-1 and (pc+3)[7:0] to SP-2. PC becomes the 16-bit operand and SP becomes SP-2.
- R4: Op 1 (page call): pc+2 is pushed the same way as in R3, SP becomes SP-2 and PC becomes {5'b00001, operand[10:0]}.
- R5: Op 2 (vector call): pc+1 is pushed the same way as in R3 and SP becomes SP-2. The new PC low byte is read from address operand[4:0] and the high byte from operand[4:0]+1, both zero-extended to 16 bits.
- R6: Op 3 (trap): the status byte is written to SP-1, (pc+1)[15:8] to SP-2 and (pc+1)[7:0] to SP-3, and SP becomes SP-3. The PC low byte is read from 003EH and the high byte from 003FH, and the interrupt-enable output is cleared.
- R7: Op 4 (return): PC low comes from (SP) and PC high from (SP+1), and SP becomes SP+2.
- R8: Op 5 (interrupt return) and op 6 (trap return) do what R7 does and also load the status byte from (SP+2), with SP becoming SP+3. `nmi_clr` is high in the `done` cycle of op 5 only.
- R9: Op 7 writes the status byte to SP-1 and SP becomes SP-1. Op 8 loads the status byte from (SP) and SP becomes SP+1.
- R10: Op 9 writes pair[15:8] to SP-1 and pair[7:0] to SP-2, and SP becomes SP-2. Op 10 loads pair[7:0] from (SP) and pair[15:8] from (SP+1), and SP becomes SP+2.
- R11: The memory port makes at most one access per cycle and none while idle. Every write lands at SP-1, SP-2 or SP-3. Read data are taken from `mem_rdata` in the cycle after the read request.
- R12: All stack pointer arithmetic, including the addresses derived from it, wraps modulo 2^16.
- R13: During reset the stack pointer output equals the parameter `SP_INIT`. `busy`, `done`, the memory strobes and the other register outputs are all zero.
- R14: Ops 11 to 15 touch no memory and leave SP unchanged. PC, status byte, pair and interrupt enable take the values presented at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin the operation on `op_in` |
| op_in | input | 4 | Operation code (encoding in R2 to R10, R14) |
| opnd_in | input | 16 | Operand: call target, page offset or vector index |
| pc_in | input | 16 | Current program counter |
| psw_in | input | 8 | Current status byte |
| pair_in | input | 16 | Current register pair |
| ie_in | input | 1 | Current interrupt-enable bit |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | Last cycle of the operation |
| pc_out | output | 16 | Updated program counter |
| sp_out | output | 16 | Stack pointer |
| psw_out | output | 8 | Updated status byte |
| pair_out | output | 16 | Updated register pair |
| ie_out | output | 1 | Updated interrupt-enable bit |
| nmi_clr | output | 1 | Clear request for the non-maskable in-service flag |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |

## Verification
Some properties are checked on every cycle. The port never reads and writes in the same cycle and is silent while idle. Every write falls one to three bytes below the stack pointer. `done` lasts a single cycle and the stack pointer moves only at the edge that ends it. `nmi_clr` never appears without `done`, and `busy` is never dropped before `done`. The bench scenarios cover the rest. They show that each operation pushes the right return address in the right byte order, picks up the right vector bytes, and takes its exact cycle count. They also sweep every vector index, cover page offsets up to the all-ones value, take the stack pointer across the 0000H/FFFFH boundary, and show that a `start` raised during a busy or done cycle is dropped.

// File: rtl/crs_pkg.sv
package crs_pkg;

    // Operation codes presented on op_in.
    typedef enum logic [3:0] {
        OP_CALL_ABS  = 4'd0,
        OP_CALL_PAGE = 4'd1,
        OP_CALL_VEC  = 4'd2,
        OP_TRAP      = 4'd3,
        OP_RTN       = 4'd4,
        OP_RTN_INT   = 4'd5,
        OP_RTN_TRAP  = 4'd6,
        OP_PSH_ST    = 4'd7,
        OP_POP_ST    = 4'd8,
        OP_PSH_PR    = 4'd9,
        OP_POP_PR    = 4'd10
    } op_e;

    typedef enum logic [1:0] {ACC_NONE, ACC_WR, ACC_RD} acc_e;

    // Address sources for one memory step.
    typedef enum logic [3:0] {
        AS_SPM1, AS_SPM2, AS_SPM3, AS_SP0, AS_SPP1, AS_SPP2,
        AS_TRAP_LO, AS_TRAP_HI, AS_VEC_LO, AS_VEC_HI
    } asel_e;

    // Write data sources.
    typedef enum logic [2:0] {WS_RETH, WS_RETL, WS_ST, WS_PRH, WS_PRL} wsel_e;

    // Destination of a read byte.
    typedef enum logic [2:0] {DS_NONE, DS_PCL, DS_PCH, DS_ST, DS_PRL, DS_PRH} dst_e;

    typedef struct packed {
        acc_e  acc;
        asel_e asel;
        wsel_e wsel;
        dst_e  dst;
    } step_t;

    localparam step_t STEP_IDLE = '{acc: ACC_NONE, asel: AS_SP0, wsel: WS_ST, dst: DS_NONE};

    function automatic step_t wr_step(asel_e a, wsel_e w);
        return '{acc: ACC_WR, asel: a, wsel: w, dst: DS_NONE};
    endfunction

    function automatic step_t rd_step(asel_e a, dst_e d);
        return '{acc: ACC_RD, asel: a, wsel: WS_ST, dst: d};
    endfunction

    // Total cycle count of each operation; unused codes take one cycle.
    function automatic logic [2:0] op_cycles(op_e op);
        case (op)
            OP_CALL_ABS:                        return 3'd7;
            OP_CALL_PAGE:                       return 3'd5;
            OP_CALL_VEC, OP_TRAP, OP_RTN,
            OP_RTN_INT, OP_RTN_TRAP:            return 3'd6;
            OP_PSH_ST, OP_POP_ST:               return 3'd2;
            OP_PSH_PR, OP_POP_PR:               return 3'd4;
            default:                            return 3'd1;
        endcase
    endfunction

    // Distance from the current pc to the pushed return address.
    function automatic logic [1:0] ret_offset(op_e op);
        case (op)
            OP_CALL_ABS:  return 2'd3;
            OP_CALL_PAGE: return 2'd2;
            default:      return 2'd1;
        endcase
    endfunction

    // Net stack pointer change, two's complement.
    function automatic logic signed [2:0] sp_adjust(op_e op);
        case (op)
            OP_CALL_ABS, OP_CALL_PAGE, OP_CALL_VEC, OP_PSH_PR: return -3'sd2;
            OP_TRAP:                                          return -3'sd3;
            OP_RTN, OP_POP_PR:                                return 3'sd2;
            OP_RTN_INT, OP_RTN_TRAP:                          return 3'sd3;
            OP_PSH_ST:                                        return -3'sd1;
            OP_POP_ST:                                        return 3'sd1;
            default:                                          return 3'sd0;
        endcase
    endfunction

endpackage

// File: rtl/crs_step_decode.sv
module crs_step_decode
    import crs_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  op_e              op,
    input  logic [CNT_W-1:0] cnt,
    output step_t            step
);

    // Memory schedule: cycle index -> access. Reads land one cycle later.
    always_comb begin
        step = STEP_IDLE;
        case (op)
            OP_CALL_ABS, OP_CALL_PAGE: begin
                case (cnt)
                    CNT_W'(1): step = wr_step(AS_SPM1, WS_RETH);
                    CNT_W'(2): step = wr_step(AS_SPM2, WS_RETL);
                    default:   step = STEP_IDLE;
                endcase
            end
            OP_CALL_VEC: begin
                case (cnt)
                    CNT_W'(1): step = wr_step(AS_SPM1, WS_RETH);
                    CNT_W'(2): step = wr_step(AS_SPM2, WS_RETL);
                    CNT_W'(3): step = rd_step(AS_VEC_LO, DS_PCL);
                    CNT_W'(4): step = rd_step(AS_VEC_HI, DS_PCH);
                    default:   step = STEP_IDLE;
                endcase
            end
            OP_TRAP: begin
                case (cnt)
                    CNT_W'(1): step = wr_step(AS_SPM1, WS_ST);
                    CNT_W'(2): step = wr_step(AS_SPM2, WS_RETH);
                    CNT_W'(3): step = wr_step(AS_SPM3, WS_RETL);
                    CNT_W'(4): step = rd_step(AS_TRAP_LO, DS_PCL);
                    CNT_W'(5): step = rd_step(AS_TRAP_HI, DS_PCH);
                    default:   step = STEP_IDLE;
                endcase
            end
            OP_RTN, OP_RTN_INT, OP_RTN_TRAP: begin
                case (cnt)
                    CNT_W'(1): step = rd_step(AS_SP0, DS_PCL);
                    CNT_W'(2): step = rd_step(AS_SPP1, DS_PCH);
                    CNT_W'(3): step = (op == OP_RTN) ? STEP_IDLE : rd_step(AS_SPP2, DS_ST);
                    default:   step = STEP_IDLE;
                endcase
            end
            OP_PSH_ST: step = (cnt == CNT_W'(1)) ? wr_step(AS_SPM1, WS_ST) : STEP_IDLE;
            OP_POP_ST: step = (cnt == CNT_W'(1)) ? rd_step(AS_SP0, DS_ST) : STEP_IDLE;
            OP_PSH_PR: begin
                case (cnt)
                    CNT_W'(1): step = wr_step(AS_SPM1, WS_PRH);
                    CNT_W'(2): step = wr_step(AS_SPM2, WS_PRL);
                    default:   step = STEP_IDLE;
                endcase
            end
            OP_POP_PR: begin
                case (cnt)
                    CNT_W'(1): step = rd_step(AS_SP0, DS_PRL);
                    CNT_W'(2): step = rd_step(AS_SPP1, DS_PRH);
                    default:   step = STEP_IDLE;
                endcase
            end
            default: step = STEP_IDLE;
        endcase
    end

endmodule

// File: rtl/crs_addr_gen.sv
module crs_addr_gen
    import crs_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter int               VEC_W    = 5,
    parameter logic [ADDR_W-1:0] TRAP_VEC = 16'h003E
) (
    input  asel_e             asel,
    input  logic [ADDR_W-1:0] sp,
    input  logic [VEC_W-1:0]  vec_idx,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] ONE   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] THREE = ADDR_W'(3);

    logic [ADDR_W-1:0] vec_base;
    assign vec_base = ADDR_W'(vec_idx);

    // Modulo 2^ADDR_W arithmetic throughout.
    always_comb begin
        case (asel)
            AS_SPM1:    addr = sp - ONE;
            AS_SPM2:    addr = sp - TWO;
            AS_SPM3:    addr = sp - THREE;
            AS_SP0:     addr = sp;
            AS_SPP1:    addr = sp + ONE;
            AS_SPP2:    addr = sp + TWO;
            AS_TRAP_LO: addr = TRAP_VEC;
            AS_TRAP_HI: addr = TRAP_VEC + ONE;
            AS_VEC_LO:  addr = vec_base;
            AS_VEC_HI:  addr = vec_base + ONE;
            default:    addr = sp;
        endcase
    end

endmodule

// File: rtl/crs_sequencer.sv
module crs_sequencer
    import crs_pkg::*;
#(
    parameter int                DW       = 8,
    parameter int                ADDR_W   = 2 * DW,
    parameter int                SHORT_W  = 11,
    parameter int                VEC_W    = 5,
    parameter logic [ADDR_W-1:0] SP_INIT  = 16'hFE20,
    parameter logic [ADDR_W-1:0] TRAP_VEC = 16'h003E,
    parameter logic [ADDR_W-SHORT_W-1:0] PAGE_HI = 5'b00001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        op_in,
    input  logic [ADDR_W-1:0] opnd_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DW-1:0]     psw_in,
    input  logic [2*DW-1:0]   pair_in,
    input  logic              ie_in,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic [DW-1:0]     psw_out,
    output logic [2*DW-1:0]   pair_out,
    output logic              ie_out,
    output logic              nmi_clr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata
);

    localparam int CNT_W = 3;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        op_e               op;
        logic [ADDR_W-1:0] opnd;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] sp;
        logic [DW-1:0]     st;
        logic [2*DW-1:0]   pr;
        logic              ie;
        dst_e              pend;
    } seq_t;

    seq_t q, d;

    step_t             step;
    logic [CNT_W-1:0]  len;
    logic [ADDR_W-1:0] ret_addr;
    logic signed [2:0] adj;

    crs_step_decode #(.CNT_W(CNT_W)) u_step (
        .op   (q.op),
        .cnt  (q.cnt),
        .step (step)
    );

    crs_addr_gen #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)) u_addr (
        .asel    (step.asel),
        .sp      (q.sp),
        .vec_idx (q.opnd[VEC_W-1:0]),
        .addr    (mem_addr)
    );

    assign len      = op_cycles(q.op);
    assign adj      = sp_adjust(q.op);
    assign ret_addr = q.pc + ADDR_W'(ret_offset(q.op));

    assign busy    = (q.cnt != '0);
    assign done    = busy && (q.cnt == len);
    assign nmi_clr = done && (q.op == OP_RTN_INT);
    assign mem_we  = (step.acc == ACC_WR);
    assign mem_re  = (step.acc == ACC_RD);

    always_comb begin
        case (step.wsel)
            WS_RETH: mem_wdata = ret_addr[2*DW-1:DW];
            WS_RETL: mem_wdata = ret_addr[DW-1:0];
            WS_PRH:  mem_wdata = q.pr[2*DW-1:DW];
            WS_PRL:  mem_wdata = q.pr[DW-1:0];
            default: mem_wdata = q.st;
        endcase
    end

    always_comb begin
        d      = q;
        d.pend = DS_NONE;
        // Byte requested in the previous cycle arrives now.
        case (q.pend)
            DS_PCL:  d.pc[DW-1:0]      = mem_rdata;
            DS_PCH:  d.pc[2*DW-1:DW]   = mem_rdata;
            DS_ST:   d.st              = mem_rdata;
            DS_PRL:  d.pr[DW-1:0]      = mem_rdata;
            DS_PRH:  d.pr[2*DW-1:DW]   = mem_rdata;
            default: ;
        endcase
        if (!busy) begin
            if (start) begin
                d.cnt  = CNT_W'(1);
                d.op   = op_e'(op_in);
                d.opnd = opnd_in;
                d.pc   = pc_in;
                d.st   = psw_in;
                d.pr   = pair_in;
                d.ie   = ie_in;
            end
        end else begin
            if (step.acc == ACC_RD) begin
                d.pend = step.dst;
            end
            if (done) begin
                d.cnt = '0;
                d.sp  = q.sp + {{(ADDR_W-3){adj[2]}}, adj};
                case (q.op)
                    OP_CALL_ABS:  d.pc = q.opnd;
                    OP_CALL_PAGE: d.pc = {PAGE_HI, q.opnd[SHORT_W-1:0]};
                    OP_TRAP:      d.ie = 1'b0;
                    default: ;
                endcase
            end else begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.op   <= OP_CALL_ABS;
            q.pend <= DS_NONE;
            q.sp   <= SP_INIT;
        end else begin
            q <= d;
        end
    end

    assign pc_out   = q.pc;
    assign sp_out   = q.sp;
    assign psw_out  = q.st;
    assign pair_out = q.pr;
    assign ie_out   = q.ie;

    // Distance from the stack pointer to the addressed byte.
    logic [ADDR_W-1:0] sp_gap;
    assign sp_gap = q.sp - mem_addr;

    a_r11_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    a_r11_write_below_sp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (sp_gap != '0 && sp_gap <= ADDR_W'(3)));

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r1_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r12_sp_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(sp_out));

    a_r8_nmi_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_clr |-> done);

    a_r6_trap_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.op == OP_TRAP) |=> !ie_out);

endmodule

// File: tb/crs_sequencer_tb_top.sv
`timescale 1ns/1ps
module crs_sequencer_tb_top;

    localparam logic [15:0] SP0 = 16'h0002;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [3:0]  op_in;
    logic [15:0] opnd_in, pc_in, pair_in;
    logic [7:0]  psw_in;
    logic        ie_in;
    logic        busy, done, ie_out, nmi_clr, mem_we, mem_re;
    logic [15:0] pc_out, sp_out, pair_out, mem_addr;
    logic [7:0]  psw_out, mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;
    int both_acc = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    crs_sequencer #(.SP_INIT(SP0)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_in), .opnd_in(opnd_in),
        .pc_in(pc_in), .psw_in(psw_in), .pair_in(pair_in), .ie_in(ie_in),
        .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out), .psw_out(psw_out),
        .pair_out(pair_out), .ie_out(ie_out), .nmi_clr(nmi_clr), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [7:0] mem [logic [15:0]];

    function automatic logic [7:0] mrd(logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mrd(mem_addr);
        if (mem_we) mem[mem_addr] = mem_wdata;
    end

    always @(negedge clk) if (rst_n && mem_we && mem_re) both_acc++;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    // Runs one operation and checks it against a model computed here.
    task automatic run_op(input string req, input logic [3:0] op, input logic [15:0] opnd,
                          input logic [15:0] pc, input logic [7:0] psw, input logic [15:0] rp,
                          input logic ie, input bit poke);
        logic [15:0] s, ret, epc, esp, erp, a5;
        logic [7:0]  epsw;
        logic        eie, enmi, seen_nmi;
        logic [15:0] wa [3];
        logic [7:0]  wd [3];
        int          nw, elen, n;
        s = sp_out; epc = pc; esp = s; erp = rp; epsw = psw; eie = ie; enmi = 0; nw = 0;
        a5 = {11'b0, opnd[4:0]};
        case (op)
            4'd0, 4'd1, 4'd2: begin
                ret = pc + ((op == 4'd0) ? 16'd3 : (op == 4'd1) ? 16'd2 : 16'd1);
                wa[0] = s - 16'd1; wd[0] = ret[15:8];
                wa[1] = s - 16'd2; wd[1] = ret[7:0]; nw = 2; esp = s - 16'd2;
                elen = (op == 4'd0) ? 7 : (op == 4'd1) ? 5 : 6;
                if (op == 4'd0) epc = opnd;
                else if (op == 4'd1) epc = {5'b00001, opnd[10:0]};
                else epc = {mrd(a5 + 16'd1), mrd(a5)};
            end
            4'd3: begin
                ret = pc + 16'd1;
                wa[0] = s - 16'd1; wd[0] = psw;
                wa[1] = s - 16'd2; wd[1] = ret[15:8];
                wa[2] = s - 16'd3; wd[2] = ret[7:0]; nw = 3;
                esp = s - 16'd3; elen = 6; eie = 0;
                epc = {mrd(16'h003F), mrd(16'h003E)};
            end
            4'd4, 4'd5, 4'd6: begin
                elen = 6; epc = {mrd(s + 16'd1), mrd(s)};
                if (op == 4'd4) esp = s + 16'd2;
                else begin esp = s + 16'd3; epsw = mrd(s + 16'd2); end
                enmi = (op == 4'd5);
            end
            4'd7: begin wa[0] = s - 16'd1; wd[0] = psw; nw = 1; esp = s - 16'd1; elen = 2; end
            4'd8: begin epsw = mrd(s); esp = s + 16'd1; elen = 2; end
            4'd9: begin
                wa[0] = s - 16'd1; wd[0] = rp[15:8];
                wa[1] = s - 16'd2; wd[1] = rp[7:0]; nw = 2; esp = s - 16'd2; elen = 4;
            end
            4'd10: begin erp = {mrd(s + 16'd1), mrd(s)}; esp = s + 16'd2; elen = 4; end
            default: elen = 1;
        endcase
        start = 1; op_in = op; opnd_in = opnd; pc_in = pc; psw_in = psw; pair_in = rp; ie_in = ie;
        @(negedge clk); start = 0; n = 1;
        while (!done && n < 20) begin
            if (poke && n == 2) begin start = 1; op_in = 4'd7; psw_in = ~psw; end
            @(negedge clk); start = 0; n++;
        end
        chk("R2", $sformatf("%s cycle count", req), n, elen);
        seen_nmi = nmi_clr;
        if (poke) begin start = 1; op_in = 4'd9; pair_in = ~rp; end
        @(negedge clk); start = 0;
        chk("R2", $sformatf("%s done width", req), done, 0);
        if (poke) chk("R1", $sformatf("%s start while busy ignored", req), {busy, mem_we, mem_re}, 0);
        chk(req, "pc", pc_out, epc);
        chk(req, "sp", sp_out, esp);
        chk(req, "psw", psw_out, epsw);
        chk(req, "pair", pair_out, erp);
        chk(req, "ie", ie_out, eie);
        chk("R8", $sformatf("%s nmi_clr", req), seen_nmi, enmi);
        for (int i = 0; i < nw; i++)
            chk(req, $sformatf("stack byte %0h", wa[i]), mrd(wa[i]), wd[i]);
    endtask

    initial begin
        rst_n = 0; start = 0; op_in = 0; opnd_in = 0; pc_in = 0; psw_in = 0; pair_in = 0; ie_in = 0;
        for (int i = 0; i < 64; i++) mem[16'(i)] = 8'(i * 13 + 5);
        repeat (3) @(negedge clk);
        chk("R13", "reset sp", sp_out, SP0);
        chk("R13", "reset flags", {busy, done, mem_we, mem_re, ie_out, nmi_clr}, 0);
        chk("R13", "reset regs", {pc_out, psw_out, pair_out}, 0);
        rst_n = 1;
        @(negedge clk);

        // R12: cross the 0000H/FFFFH boundary both ways.
        run_op("R10", 4'd9, 0, 16'h1234, 8'h11, 16'hA1B2, 1'b1, 0);
        chk("R12", "sp after wrap push", sp_out, 16'h0000);
        run_op("R9", 4'd7, 0, 16'h1234, 8'h5A, 16'h0, 1'b0, 0);
        chk("R12", "sp at FFFF", sp_out, 16'hFFFF);
        run_op("R9", 4'd8, 0, 16'h1234, 8'h00, 16'h0, 1'b0, 1);
        chk("R12", "sp back to 0000", sp_out, 16'h0000);
        run_op("R10", 4'd10, 0, 16'h1234, 8'h00, 16'h0, 1'b0, 0);
        chk("R12", "sp back to 0002", sp_out, SP0);

        // Move the stack away from the vector table.
        for (int i = 0; i < 9; i++)
            run_op("R10", 4'd9, 0, 16'h0, 8'h0, 16'(16'h3C00 + i * 16'h0111), 1'b0, 0);

        for (int a = 0; a < 32; a++) begin
            run_op("R5", 4'd2, 16'(a) | 16'hFFE0, 16'(16'h1000 + a * 37), 8'(a), 16'(a), 1'b1, a == 5);
            run_op("R7", 4'd4, 0, 16'h0, 8'(a), 16'h0, 1'b0, a == 6);
        end
        for (int k = 0; k < 16; k++) begin
            run_op("R3", 4'd0, 16'hC000 ^ 16'(k * 16'h1111), 16'(k * 16'h0F0F), 8'h3C, 16'h0, 1'b1, k == 3);
            run_op("R7", 4'd4, 0, 16'h0, 8'h3C, 16'h0, 1'b1, 0);
            run_op("R4", 4'd1, (k == 15) ? 16'hFFFF : 16'(k * 137), 16'(16'hFFFE - k), 8'h00, 16'h0, 1'b0, 0);
            run_op("R7", 4'd4, 0, 16'h0, 8'h00, 16'h0, 1'b0, 0);
        end
        for (int k = 0; k < 8; k++) begin
            run_op("R6", 4'd3, 0, 16'(16'h2000 + k * 16'h0333), 8'(k * 8'h21), 16'h0, 1'b1, k == 2);
            run_op("R8", (k % 2 == 0) ? 4'd5 : 4'd6, 0, 16'h0, 8'h00, 16'h0, 1'b1, 0);
        end
        for (int k = 0; k < 8; k++) begin
            run_op("R9", 4'd7, 0, 16'h0, 8'(8'hC3 ^ k), 16'h0, 1'b0, 1);
            run_op("R9", 4'd8, 0, 16'h0, 8'h00, 16'h0, 1'b0, 0);
            run_op("R10", 4'd9, 0, 16'h0, 8'h00, 16'(16'h8001 + k * 16'h1357), 1'b0, 1);
            run_op("R10", 4'd10, 0, 16'h0, 8'h00, 16'h0000, 1'b0, 0);
        end
        for (int c = 11; c < 16; c++)
            run_op("R14", 4'(c), 16'hFFFF, 16'(c * 16'h0101), 8'(c), 16'(c * 16'h1001), 1'b1, 0);

        chk("R11", "cycles with read and write together", both_acc, 0);
        summary();
    end

endmodule